// File: doc/BRIEF.md
# Subscriber line mode sequencer

This block drives the four mode pins of an analog line interface device: a power-enable pin and three control bits. It also watches that device's active-low loop-status line. A host issues one of four commands: idle monitoring, talk, polarity select or ring. The sequencer turns each command into the right pin code.

For ringing, the block produces the ring waveform by flipping the polarity bit at a programmed half-period. It does this inside timed bursts, and inserts pauses between them. While the line rings, a low loop status means the handset was lifted (ring trip). In that case the block first freezes the polarity bit and then settles the line into talk with normal polarity. A short blanking window at the start of ringing keeps switching transients from being read as a trip.

Loop status is synchronised and debounced into a clean level and one-cycle events. A talk line that stays on-hook long enough falls back to idle on its own. A thermal-overload input forces power-down, and the previous mode returns once the overload clears. All durations count a tick of about 1 ms, derived from the clock. The tick and the cadence timers restart on every state change and on every accepted command.

Top module: `line_mode_seq`

## Requirements
- R1: After reset the pins show high-impedance feed, written {pwr,b0,b1,b2} = 1,0,0,0. hook_off is low and no event, trip or error pulse is raised.
- R2: Command code 1 (talk) drives active normal polarity 1,0,1,0, and command code 0 (idle) drives 1,0,0,0. The pattern with both b0 and b1 high is never driven while pwr is high.
- R3: Command code 3 (polarity) in talk mode changes only b2, to cmd_rev, where 0 is normal and 1 is reversed. In any other mode it leaves the pins unchanged.
- R4: Command code 2 (ring), accepted while on-hook, drives 1,1,0,b2. b2 starts at 0 and inverts every cfg_half ticks: 25 ticks gives 20 Hz and 20 ticks gives 25 Hz. b2 changes within a ring code only on a tick.
- R5: A ring burst lasts cfg_burst ticks and is followed by a pause of cfg_pause ticks at 1,0,1,0. Bursts then resume, each starting again with b2 = 0.
- R6: A ring command while hook_off is high is rejected. err_reject pulses for one cycle and the pins keep their code.
- R7: det_n passes through two flops. hook_off changes only after the synchronised input has differed from it on cfg_debounce consecutive ticks. Shorter glitches are ignored. evt_off and evt_on pulse once on each accepted change. evt_off is withheld while ringing, and at most one of evt_off, evt_on and evt_trip is high at a time.
- R8: A debounced off-hook during a burst is a ring trip. evt_trip pulses, and ring code is held with b2 frozen until the next tick. The line then goes to 1,0,1,0. Whenever the ring code is left while powered, b2 is 0.
- R9: During the first cfg_blank ticks of the first burst after a ring command, off-hook is ignored and ringing continues. A trip is taken in the cycle after the window ends.
- R10: A debounced off-hook during a pause ends ringing and leaves the line at 1,0,1,0. evt_off is raised and no further burst follows.
- R11: In talk mode, once hook_off has been low for cfg_idle ticks, the pins return to 1,0,0,0.
- R12: Two cycles after therm_ovl rises, the pins are all 0. While it stays high, commands and timers are frozen. When it clears, the earlier pin code returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_n | input | 1 | Loop status from line device, low = off-hook or ring trip |
| therm_ovl | input | 1 | Thermal overload, high forces power-down |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 2 | 0 idle, 1 talk, 2 ring, 3 polarity |
| cmd_rev | input | 1 | Polarity for code 3, 1 = reversed |
| cfg_half | input | TW | Ticks per half ring period |
| cfg_burst | input | TW | Ring burst length in ticks |
| cfg_pause | input | TW | Ring pause length in ticks |
| cfg_debounce | input | TW | Ticks of stable status before acceptance |
| cfg_blank | input | TW | Trip blanking ticks at ring start |
| cfg_idle | input | TW | On-hook ticks before fallback to idle |
| mpin_pd | output | 1 | Power pin, 0 = power-down |
| mpin_b0 | output | 1 | Mode bit 0 |
| mpin_b1 | output | 1 | Mode bit 1 |
| mpin_b2 | output | 1 | Polarity bit, toggled for ringing |
| hook_off | output | 1 | Debounced off-hook level |
| evt_off | output | 1 | Off-hook event pulse |
| evt_on | output | 1 | On-hook event pulse |
| evt_trip | output | 1 | Ring trip event pulse |
| err_reject | output | 1 | Rejected ring request pulse |

## Verification
The bench builds the block with CLK_PER_TICK = 4 and a half period of 2 ticks, an 8-tick burst, a 6-tick pause, 3-tick debounce, 6-tick blanking and a 10-tick idle limit. At these values a whole burst, pause and second burst fit in under a hundred clocks. Every cycle of the cadence, the trip hold, the debounce window and the idle fallback can therefore be compared against pin codes that the bench derives from tick arithmetic. The small tick also puts the race between blanking expiry and the polarity toggle within a short sweep, along with a trip taken while b2 is high.

// File: rtl/lms_pkg.sv
package lms_pkg;

  typedef enum logic [2:0] {
    ST_HIZ,
    ST_ACT,
    ST_BURST,
    ST_PAUSE,
    ST_HALT
  } lms_state_e;

  localparam logic [1:0] CMD_IDLE = 2'd0;
  localparam logic [1:0] CMD_TALK = 2'd1;
  localparam logic [1:0] CMD_RING = 2'd2;
  localparam logic [1:0] CMD_POL  = 2'd3;

  // a count has reached its limit when count+1 meets it; a zero limit acts as one
  function automatic logic at_limit(input logic [31:0] cnt, input logic [31:0] lim);
    logic [31:0] l;
    l = (lim == 32'd0) ? 32'd1 : lim;
    return (cnt + 32'd1) >= l;
  endfunction

  // pin code {pwr, b0, b1, b2} for a state
  function automatic logic [3:0] mode_pins(input lms_state_e st, input logic rev,
                                           input logic ph, input logic ovl);
    logic [3:0] p;
    if (ovl) p = 4'b0000;
    else begin
      case (st)
        ST_HIZ:            p = 4'b1000;
        ST_ACT:            p = {3'b101, rev};
        ST_BURST, ST_HALT: p = {3'b110, ph};
        ST_PAUSE:          p = 4'b1010;
        default:           p = 4'b0000;
      endcase
    end
    return p;
  endfunction

endpackage

// File: rtl/lms_tick.sv
module lms_tick #(
  parameter int CLK_PER_TICK = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic restart,
  output logic tick
);
  localparam int CW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_TICK - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (en)      cnt <= tick ? '0 : cnt + CW'(1);
  end
endmodule

// File: rtl/lms_debounce.sv
module lms_debounce
  import lms_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          det_n,
  input  logic          tick,
  input  logic [TW-1:0] lim,
  output logic          lvl,
  output logic          rise,
  output logic          fall
);
  logic s1, s2;
  logic [TW-1:0] cnt;
  logic raw_off;

  assign raw_off = ~s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1;
      lvl <= 1'b0; rise <= 1'b0; fall <= 1'b0;
      cnt <= '0;
    end else begin
      s1 <= det_n;
      s2 <= s1;
      rise <= 1'b0;
      fall <= 1'b0;
      if (raw_off == lvl) cnt <= '0;
      else if (tick) begin
        if (at_limit(32'(cnt), 32'(lim))) begin
          lvl  <= raw_off;
          rise <= raw_off;
          fall <= ~raw_off;
          cnt  <= '0;
        end else cnt <= cnt + TW'(1);
      end
    end
  end
endmodule

// File: rtl/lms_ring_phase.sv
module lms_ring_phase
  import lms_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          adv,
  input  logic [TW-1:0] half,
  output logic          ph
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; ph <= 1'b0;
    end else if (clear) begin
      cnt <= '0; ph <= 1'b0;
    end else if (adv) begin
      if (at_limit(32'(cnt), 32'(half))) begin
        cnt <= '0;
        ph  <= ~ph;
      end else cnt <= cnt + TW'(1);
    end
  end
endmodule

// File: rtl/line_mode_seq.sv
module line_mode_seq
  import lms_pkg::*;
#(
  parameter int CLK_PER_TICK = 250000,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          det_n,
  input  logic          therm_ovl,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_code,
  input  logic          cmd_rev,
  input  logic [TW-1:0] cfg_half,
  input  logic [TW-1:0] cfg_burst,
  input  logic [TW-1:0] cfg_pause,
  input  logic [TW-1:0] cfg_debounce,
  input  logic [TW-1:0] cfg_blank,
  input  logic [TW-1:0] cfg_idle,
  output logic          mpin_pd,
  output logic          mpin_b0,
  output logic          mpin_b1,
  output logic          mpin_b2,
  output logic          hook_off,
  output logic          evt_off,
  output logic          evt_on,
  output logic          evt_trip,
  output logic          err_reject
);
  lms_state_e st, st_nxt;
  logic rev, rev_nxt;
  logic ovl_s1, ovl_s;
  logic run, tick_w, restart, cmd_take, trip_now, rej_now;
  logic rise_w, fall_w, ph, ring_adv, ring_clr, blank_ok, first_burst;
  logic [TW-1:0] dcnt, blank_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin ovl_s1 <= 1'b0; ovl_s <= 1'b0; end
    else begin ovl_s1 <= therm_ovl; ovl_s <= ovl_s1; end
  end

  assign run      = ~ovl_s;
  assign cmd_take = run && cmd_valid;
  assign blank_ok = !first_burst || (blank_cnt >= cfg_blank);

  always_comb begin
    st_nxt = st; rev_nxt = rev; trip_now = 1'b0; rej_now = 1'b0;
    if (cmd_take) begin
      case (cmd_code)
        CMD_IDLE: begin st_nxt = ST_HIZ; rev_nxt = 1'b0; end
        CMD_TALK: begin st_nxt = ST_ACT; rev_nxt = 1'b0; end
        CMD_RING: if (hook_off) rej_now = 1'b1; else st_nxt = ST_BURST;
        default:  if (st == ST_ACT) rev_nxt = cmd_rev;
      endcase
    end else if (run) begin
      case (st)
        ST_ACT:
          if (tick_w && !hook_off && at_limit(32'(dcnt), 32'(cfg_idle))) st_nxt = ST_HIZ;
        ST_BURST:
          if (hook_off && blank_ok) begin st_nxt = ST_HALT; trip_now = 1'b1; end
          else if (tick_w && at_limit(32'(dcnt), 32'(cfg_burst))) st_nxt = ST_PAUSE;
        ST_PAUSE:
          if (hook_off) begin st_nxt = ST_ACT; rev_nxt = 1'b0; end
          else if (tick_w && at_limit(32'(dcnt), 32'(cfg_pause))) st_nxt = ST_BURST;
        ST_HALT:
          if (tick_w) begin st_nxt = ST_ACT; rev_nxt = 1'b0; end
        default: ;
      endcase
    end
  end

  assign restart  = cmd_take || (st_nxt != st);
  assign ring_adv = tick_w && (st == ST_BURST) && (st_nxt == ST_BURST);
  assign ring_clr = (st != ST_BURST) && (st != ST_HALT);

  lms_tick #(.CLK_PER_TICK(CLK_PER_TICK)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(run), .restart(restart), .tick(tick_w)
  );

  lms_debounce #(.TW(TW)) u_deb (
    .clk(clk), .rst_n(rst_n), .det_n(det_n), .tick(tick_w), .lim(cfg_debounce),
    .lvl(hook_off), .rise(rise_w), .fall(fall_w)
  );

  lms_ring_phase #(.TW(TW)) u_ring (
    .clk(clk), .rst_n(rst_n), .clear(ring_clr), .adv(ring_adv), .half(cfg_half), .ph(ph)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_HIZ; rev <= 1'b0; dcnt <= '0; blank_cnt <= '0; first_burst <= 1'b0;
      evt_trip <= 1'b0; err_reject <= 1'b0;
    end else begin
      st <= st_nxt;
      rev <= rev_nxt;
      evt_trip <= trip_now;
      err_reject <= rej_now;
      if (restart || (st == ST_ACT && hook_off)) dcnt <= '0;
      else if (tick_w && dcnt != '1) dcnt <= dcnt + TW'(1);
      if (cmd_take && cmd_code == CMD_RING && !hook_off) begin
        blank_cnt <= '0; first_burst <= 1'b1;
      end else if (st == ST_PAUSE) first_burst <= 1'b0;
      else if (st == ST_BURST && tick_w && blank_cnt < cfg_blank) blank_cnt <= blank_cnt + TW'(1);
    end
  end

  assign {mpin_pd, mpin_b0, mpin_b1, mpin_b2} = mode_pins(st, rev, ph, ovl_s);
  assign evt_off = rise_w && (st != ST_BURST) && (st != ST_HALT);
  assign evt_on  = fall_w;
endmodule

// File: rtl/lms_chk.sv
module lms_chk (
  input logic clk,
  input logic rst_n,
  input logic therm_ovl,
  input logic cmd_valid,
  input logic hook_off,
  input logic mpin_pd,
  input logic mpin_b0,
  input logic mpin_b1,
  input logic mpin_b2,
  input logic tick_w,
  input logic evt_off,
  input logic evt_on,
  input logic evt_trip,
  input logic err_reject
);
  // R12
  ovl_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && therm_ovl && $past(therm_ovl)) |=> (!mpin_pd && !mpin_b0 && !mpin_b1));

  // R8
  trip_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_trip && mpin_pd) |-> (mpin_b0 && !mpin_b1 && $stable(mpin_b2)));

  // R8
  ring_exit_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mpin_b0) && !mpin_b0 && mpin_pd) |-> !mpin_b2);

  // R4
  toggle_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mpin_b0 && $past(mpin_b0) && (mpin_b2 != $past(mpin_b2))) |-> $past(tick_w));

  // R6
  reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_reject |-> ($past(cmd_valid) && $past(hook_off)));

  // R7
  evt_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_off, evt_on, evt_trip}));

  // R7
  off_evt_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_off |-> (hook_off && !$past(hook_off)));

  // R2
  no_dual_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mpin_pd |-> !(mpin_b0 && mpin_b1));
endmodule

bind line_mode_seq lms_chk u_chk (
  .clk(clk), .rst_n(rst_n), .therm_ovl(therm_ovl), .cmd_valid(cmd_valid),
  .hook_off(hook_off), .mpin_pd(mpin_pd), .mpin_b0(mpin_b0), .mpin_b1(mpin_b1),
  .mpin_b2(mpin_b2), .tick_w(tick_w), .evt_off(evt_off), .evt_on(evt_on),
  .evt_trip(evt_trip), .err_reject(err_reject)
);

// File: tb/tb_line_mode_seq.sv
module tb_line_mode_seq;
  localparam int CPT = 4, TW = 16;
  localparam int HALF = 2, BURST = 8, PAUSE = 6, DEB = 3, BLANK = 6, IDLE = 10;

  logic clk = 1'b0, rst_n = 1'b0, det_n = 1'b1, therm_ovl = 1'b0;
  logic cmd_valid = 1'b0, cmd_rev = 1'b0;
  logic [1:0] cmd_code = 2'd0;
  logic mpin_pd, mpin_b0, mpin_b1, mpin_b2, hook_off, evt_off, evt_on, evt_trip, err_reject;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  line_mode_seq #(.CLK_PER_TICK(CPT), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .det_n(det_n), .therm_ovl(therm_ovl),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_rev(cmd_rev),
    .cfg_half(TW'(HALF)), .cfg_burst(TW'(BURST)), .cfg_pause(TW'(PAUSE)),
    .cfg_debounce(TW'(DEB)), .cfg_blank(TW'(BLANK)), .cfg_idle(TW'(IDLE)),
    .mpin_pd(mpin_pd), .mpin_b0(mpin_b0), .mpin_b1(mpin_b1), .mpin_b2(mpin_b2),
    .hook_off(hook_off), .evt_off(evt_off), .evt_on(evt_on), .evt_trip(evt_trip),
    .err_reject(err_reject)
  );

  wire [3:0] pins = {mpin_pd, mpin_b0, mpin_b1, mpin_b2};

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // pin code k cycles after a ring command edge, ring continuing undisturbed
  function automatic int ring_exp(input int k);
    int b = BURST * CPT, p = PAUSE * CPT;
    if (k < b) return 4'b1100 | ((k / (HALF * CPT)) % 2);
    if (k < b + p) return 4'b1010;
    return 4'b1100 | (((k - b - p) / (HALF * CPT)) % 2);
  endfunction

  task automatic send(input logic [1:0] code, input logic rv);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_rev = rv;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pins", pins, 4'b1000);
    chk("R1 hook", hook_off, 0);
    chk("R1 events", {evt_off, evt_on, evt_trip, err_reject}, 0);

    send(2'd1, 1'b0); chk("R2 talk", pins, 4'b1010);
    send(2'd3, 1'b1); chk("R3 reverse", pins, 4'b1011);
    send(2'd3, 1'b0); chk("R3 normal", pins, 4'b1010);
    send(2'd0, 1'b0); chk("R2 idle", pins, 4'b1000);
    send(2'd3, 1'b1); chk("R3 ignored in idle", pins, 4'b1000);

    // R4 R5 full cadence sweep
    send(2'd2, 1'b0);
    for (int k = 0; k < 88; k++) begin
      chk("R4 R5 cadence", pins, ring_exp(k));
      chk("R5 no events", {evt_off, evt_trip}, 0);
      @(negedge clk);
    end
    send(2'd0, 1'b0); chk("R2 idle after ring", pins, 4'b1000);

    // R9 blanking then R8 trip
    send(2'd2, 1'b0);
    det_n = 1'b0;
    for (int k = 0; k < 41; k++) begin
      int e;
      if (k <= 24) e = ring_exp(k);
      else if (k <= 28) e = 4'b1101;
      else e = 4'b1010;
      chk("R9 R8 trip pins", pins, e);
      chk("R8 trip event", evt_trip, (k == 25) ? 1 : 0);
      chk("R7 off withheld", evt_off, 0);
      chk("R7 debounced level", hook_off, (k >= 12) ? 1 : 0);
      @(negedge clk);
    end

    // R6 reject
    send(2'd2, 1'b0);
    chk("R6 err pulse", err_reject, 1);
    chk("R6 pins kept", pins, 4'b1010);
    @(negedge clk);
    chk("R6 err one cycle", err_reject, 0);

    // R7 on-hook event, R11 idle fallback
    send(2'd1, 1'b0);
    det_n = 1'b1;
    for (int k = 0; k < 61; k++) begin
      chk("R7 level on", hook_off, (k < 12) ? 1 : 0);
      chk("R7 on event", evt_on, (k == 12) ? 1 : 0);
      chk("R11 fallback", pins, (k < 52) ? 4'b1010 : 4'b1000);
      @(negedge clk);
    end

    // R7 glitch shorter than debounce
    send(2'd0, 1'b0);
    for (int k = 0; k < 40; k++) begin
      if (k == 0) det_n = 1'b0;
      if (k == 5) det_n = 1'b1;
      chk("R7 glitch level", hook_off, 0);
      chk("R7 glitch event", evt_off, 0);
      @(negedge clk);
    end

    // R7 off-hook in idle
    send(2'd0, 1'b0);
    det_n = 1'b0;
    for (int k = 0; k < 21; k++) begin
      chk("R7 idle off level", hook_off, (k >= 12) ? 1 : 0);
      chk("R7 idle off event", evt_off, (k == 12) ? 1 : 0);
      chk("R7 idle pins", pins, 4'b1000);
      @(negedge clk);
    end
    det_n = 1'b1;
    repeat (30) @(negedge clk);
    chk("R7 back on-hook", hook_off, 0);

    // R10 off-hook during pause
    send(2'd2, 1'b0);
    for (int k = 0; k < 96; k++) begin
      if (k == 33) det_n = 1'b0;
      chk("R10 pins", pins, (k < 32) ? ring_exp(k) : 4'b1010);
      chk("R10 off event", evt_off, (k == 44) ? 1 : 0);
      chk("R10 no trip", evt_trip, 0);
      @(negedge clk);
    end

    // R12 thermal overload
    send(2'd1, 1'b0);
    send(2'd3, 1'b1);
    therm_ovl = 1'b1;
    for (int k = 0; k < 31; k++) begin
      if (k == 5) begin cmd_valid = 1'b1; cmd_code = 2'd2; end
      if (k == 6) cmd_valid = 1'b0;
      if (k == 20) therm_ovl = 1'b0;
      chk("R12 pins", pins, (k >= 2 && k < 22) ? 4'b0000 : 4'b1011);
      chk("R12 cmd ignored", err_reject, 0);
      @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule